// File: doc/BRIEF.md
# Trace Message Queue with Overrun Error Insertion

This block is the shared queue that sits between the trace message generators of a debug unit and the port that carries those messages off chip. Four message classes feed one write port: ownership changes, program-flow trace, data trace and watchpoint hits. Each entry is up to 15 bits wide and carries a 4-bit length tag, so messages of different lengths can share the same storage. The consumer takes entries from the head with a valid/ready handshake.

When a message arrives while every slot is occupied, the queue enters an overrun episode. It then refuses every arrival, even after slots have freed up, until the consumer has taken the last stored entry. During the episode it remembers which classes it refused. In the first cycle that finds the queue empty, it writes one 15-bit error entry whose 5-bit code summarises the refused classes. It then returns to normal acceptance. An arrival in that same cycle is kept and is queued directly behind the error entry.

Top module: `trace_ovf_queue`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `out_valid` is low and the queue holds nothing.
- R2: Outside an overrun episode, an arrival that finds the queue not full is stored. Entries leave in arrival order with their data and length tag unchanged.
- R3: An arrival that finds the queue holding DEPTH entries starts an overrun episode and is discarded. This holds even if the consumer removes an entry in that same cycle.
- R4: During an episode, every arrival is discarded while the queue still holds at least one entry, including arrivals that come after slots have freed up.
- R5: In the first cycle of an episode in which the queue is empty, exactly one error entry is written, and the episode ends.
- R6: The error entry has length tag 15. Bits [5:0] hold 6'b001000, bits [9:6] hold `src_id`, and bits [14:10] hold the error code.
- R7: Class encoding on `in_class`: 0 ownership, 1 program trace, 2 data trace, 3 watchpoint. If only class 0 was refused in the episode, the code is 5'b00000.
- R8: If class 1 or class 2 (program or data trace) was refused and class 3 was not, the code is 5'b00111, whether or not class 0 was also refused.
- R9: If class 3 (watchpoint) was refused, the code is 5'b01000, whatever else was refused.
- R10: An arrival in the cycle the error entry is written is accepted and leaves directly after the error entry.
- R11: Refused-class records clear when the error entry is written, so the code of a later episode reflects only that episode's refusals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_id | input | 4 | Static source identifier placed in error entries |
| in_valid | input | 1 | A message is offered this cycle |
| in_class | input | 2 | Class of the offered message (0 own, 1 program, 2 data, 3 watchpoint) |
| in_data | input | 15 | Message payload, LSB-aligned |
| in_len | input | 4 | Number of valid payload bits |
| out_ready | input | 1 | Consumer takes the head entry this cycle |
| out_valid | output | 1 | Head entry present |
| out_data | output | 15 | Head entry payload |
| out_len | output | 4 | Head entry length tag |

## Verification
The bench builds the queue with its default depth of four and a source identifier of 4'hA. With that depth, the queue fills after four arrivals, so each overrun episode fits in a few cycles. This makes it practical to run all six refused-class mixtures, several of them back to back to show that the records clear between episodes. The small depth also allows two edge cases to be timed exactly: the case where an arrival and a removal at a full queue coincide, and the case where an arrival lands in the cycle the error entry is written.

// File: rtl/trq_pkg.sv
package trq_pkg;

    localparam int MSG_W   = 15;
    localparam int LEN_W   = 4;
    localparam int SRC_W   = 4;
    localparam int CODE_W  = 5;
    localparam int TAG_W   = 6;
    localparam int NCLS    = 4;

    localparam logic [TAG_W-1:0]  ERR_TAG       = 6'b001000;
    localparam logic [CODE_W-1:0] CODE_OWN_ONLY = 5'b00000;
    localparam logic [CODE_W-1:0] CODE_TRACE    = 5'b00111;
    localparam logic [CODE_W-1:0] CODE_WATCH    = 5'b01000;
    localparam logic [LEN_W-1:0]  ERR_LEN       = LEN_W'(MSG_W);

    typedef enum logic [1:0] {
        CLS_OWN   = 2'd0,
        CLS_PROG  = 2'd1,
        CLS_DATA  = 2'd2,
        CLS_WATCH = 2'd3
    } msg_class_e;

    typedef enum logic {
        OV_RUN   = 1'b0,
        OV_DRAIN = 1'b1
    } ovf_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [MSG_W-1:0] data;
    } entry_t;

endpackage

// File: rtl/trq_fifo.sv
module trq_fifo
    import trq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr0_en,
    input  entry_t           wr0_ent,
    input  logic             wr1_en,
    input  entry_t           wr1_ent,
    input  logic             rd_en,
    output entry_t           rd_ent,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]   rd;
        logic [PTR_W-1:0]   wr;
        logic [CNT_W-1:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        logic [PTR_W-1:0] wp;
        logic             do_rd;
        logic [1:0]       nwr;
        st_d  = st_q;
        wp    = st_q.wr;
        nwr   = 2'd0;
        do_rd = rd_en && (st_q.cnt != '0);
        if (wr0_en) begin
            st_d.mem[wp] = wr0_ent;
            wp           = ptr_inc(wp);
            nwr          = nwr + 2'd1;
        end
        if (wr1_en) begin
            st_d.mem[wp] = wr1_ent;
            wp           = ptr_inc(wp);
            nwr          = nwr + 2'd1;
        end
        st_d.wr = wp;
        if (do_rd) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CNT_W'(nwr) - CNT_W'(do_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ent = st_q.mem[st_q.rd];
    assign cnt    = st_q.cnt;
    assign full   = (st_q.cnt == CNT_W'(DEPTH));
    assign empty  = (st_q.cnt == '0);

endmodule

// File: rtl/trq_ovf_ctrl.sv
module trq_ovf_ctrl
    import trq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  msg_class_e      in_class,
    input  logic            q_full,
    input  logic            q_empty,
    output logic            push_err,
    output logic            push_msg,
    output logic            in_drain,
    output logic [NCLS-1:0] refused
);

    typedef struct packed {
        ovf_state_e      st;
        logic [NCLS-1:0] refused;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        push_err = 1'b0;
        push_msg = 1'b0;
        case (st_q.st)
            OV_RUN: begin
                if (in_valid) begin
                    if (q_full) begin
                        st_d.st                = OV_DRAIN;
                        st_d.refused[in_class] = 1'b1;
                    end else begin
                        push_msg = 1'b1;
                    end
                end
            end
            OV_DRAIN: begin
                if (q_empty) begin
                    push_err     = 1'b1;
                    push_msg     = in_valid;
                    st_d.refused = '0;
                    st_d.st      = OV_RUN;
                end else if (in_valid) begin
                    st_d.refused[in_class] = 1'b1;
                end
            end
            default: begin
                st_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_drain = (st_q.st == OV_DRAIN);
    assign refused  = st_q.refused;

endmodule

// File: rtl/trq_err_word.sv
module trq_err_word
    import trq_pkg::*;
(
    input  logic [NCLS-1:0]  refused,
    input  logic [SRC_W-1:0] src_id,
    output entry_t           err_ent
);

    logic [CODE_W-1:0] code;

    always_comb begin
        if (refused[CLS_WATCH]) begin
            code = CODE_WATCH;
        end else if (refused[CLS_PROG] || refused[CLS_DATA]) begin
            code = CODE_TRACE;
        end else begin
            code = CODE_OWN_ONLY;
        end
    end

    always_comb begin
        err_ent      = '0;
        err_ent.len  = ERR_LEN;
        err_ent.data = {code, src_id, ERR_TAG};
    end

endmodule

// File: rtl/trace_ovf_queue.sv
module trace_ovf_queue
    import trq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  src_id,
    input  logic        in_valid,
    input  logic [1:0]  in_class,
    input  logic [14:0] in_data,
    input  logic [3:0]  in_len,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [14:0] out_data,
    output logic [3:0]  out_len
);

    entry_t           in_ent;
    entry_t           err_ent;
    entry_t           head_ent;
    entry_t           wr0_ent;
    logic             wr0_en;
    logic             wr1_en;
    logic             push_err;
    logic             push_msg;
    logic             ovf_drain;
    logic [NCLS-1:0]  refused;
    logic [CNT_W-1:0] q_cnt;
    logic             q_full;
    logic             q_empty;

    assign in_ent.data = in_data;
    assign in_ent.len  = in_len;

    trq_ovf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_class (msg_class_e'(in_class)),
        .q_full   (q_full),
        .q_empty  (q_empty),
        .push_err (push_err),
        .push_msg (push_msg),
        .in_drain (ovf_drain),
        .refused  (refused)
    );

    trq_err_word u_err (
        .refused (refused),
        .src_id  (src_id),
        .err_ent (err_ent)
    );

    assign wr0_en  = push_err | push_msg;
    assign wr0_ent = push_err ? err_ent : in_ent;
    assign wr1_en  = push_err & push_msg;

    trq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr0_en  (wr0_en),
        .wr0_ent (wr0_ent),
        .wr1_en  (wr1_en),
        .wr1_ent (in_ent),
        .rd_en   (out_ready),
        .rd_ent  (head_ent),
        .cnt     (q_cnt),
        .full    (q_full),
        .empty   (q_empty)
    );

    assign out_valid = !q_empty;
    assign out_data  = head_ent.data;
    assign out_len   = head_ent.len;

endmodule

// File: rtl/trq_chk.sv
module trq_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       src_id,
    input logic             out_valid,
    input logic             drain,
    input logic [CNT_W-1:0] q_cnt,
    input logic             push_err,
    input logic [14:0]      err_data,
    input logic [3:0]       err_len
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R3
    overrun_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain && in_valid && q_cnt == CNT_W'(DEPTH)) |=> drain);

    // R4
    drain_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && q_cnt != '0) |=> (q_cnt <= $past(q_cnt)));

    // R5
    single_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && q_cnt == '0) |=> (!drain && q_cnt != '0));

    // R6
    err_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_err |-> (err_data[5:0] == 6'b001000 && err_data[9:6] == src_id
                      && err_len == 4'd15));

    // R10
    err_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_err && in_valid) |=> (q_cnt == CNT_W'(2)));

endmodule

bind trace_ovf_queue trq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_id    (src_id),
    .out_valid (out_valid),
    .drain     (ovf_drain),
    .q_cnt     (q_cnt),
    .push_err  (push_err),
    .err_data  (err_ent.data),
    .err_len   (err_ent.len)
);

// File: tb/sim_trace_ovf_queue.sv
module sim_trace_ovf_queue;

    localparam int   DEPTH = 4;
    localparam logic [3:0] SRC = 4'hA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_class = 2'd0;
    logic [14:0] in_data = '0;
    logic [3:0]  in_len = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [14:0] out_data;
    logic [3:0]  out_len;

    int total = 0;
    int bad = 0;
    logic [14:0] got_d [32];
    logic [3:0]  got_l [32];
    int ngot = 0;

    always #5 clk = ~clk;

    trace_ovf_queue #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .src_id(SRC),
        .in_valid(in_valid), .in_class(in_class), .in_data(in_data), .in_len(in_len),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .out_len(out_len)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] err_word(logic [4:0] code);
        return {code, SRC, 6'b001000};
    endfunction

    task automatic send(logic [1:0] cls, logic [14:0] d, logic [3:0] l);
        @(negedge clk);
        in_valid = 1'b1; in_class = cls; in_data = d; in_len = l;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic record();
        got_d[ngot] = out_data;
        got_l[ngot] = out_len;
        ngot++;
    endtask

    task automatic drain_all();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
            if (out_valid) record();
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic fill(logic [14:0] base);
        for (int k = 0; k < DEPTH; k++) send(2'd0, base + 15'(k), 4'(k + 3));
    endtask

    task automatic check_fill(string req, logic [14:0] base);
        for (int k = 0; k < DEPTH; k++) begin
            check({req, " fill data"}, 32'(got_d[k]), 32'(base + 15'(k)));
            check({req, " fill len"}, 32'(got_l[k]), 32'(k + 3));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic t_order();
        ngot = 0;
        send(2'd1, 15'h0111, 4'd5);
        send(2'd3, 15'h2222, 4'd12);
        send(2'd2, 15'h7333, 4'd15);
        drain_all();
        check("R2 count", 32'(ngot), 32'd3);
        check("R2 d0", 32'(got_d[0]), 32'h0111);
        check("R2 l0", 32'(got_l[0]), 32'd5);
        check("R2 d1", 32'(got_d[1]), 32'h2222);
        check("R2 l1", 32'(got_l[1]), 32'd12);
        check("R2 d2", 32'(got_d[2]), 32'h7333);
        check("R2 l2", 32'(got_l[2]), 32'd15);
    endtask

    // Trigger while full, then inject extra classes while the queue still holds entries (R4).
    task automatic t_overrun(string req, logic [1:0] trig, int nx, logic [1:0] x0,
                             logic [1:0] x1, logic [4:0] code);
        ngot = 0;
        fill(15'h0100);
        send(trig, 15'h5555, 4'd7);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
            if (out_valid) record();
            in_valid = (i < nx);
            in_class = (i == 0) ? x0 : x1;
            in_data  = 15'h6666;
            in_len   = 4'd9;
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
        check({req, " R4 entries"}, 32'(ngot), 32'(DEPTH + 1));
        check_fill({req, " R4"}, 15'h0100);
        check({req, " R5 R6 err word"}, 32'(got_d[DEPTH]), 32'(err_word(code)));
        check({req, " R6 err len"}, 32'(got_l[DEPTH]), 32'd15);
    endtask

    task automatic t_full_pop();
        ngot = 0;
        fill(15'h0100);
        @(negedge clk);
        out_ready = 1'b1;
        in_valid = 1'b1; in_class = 2'd1; in_data = 15'h4444; in_len = 4'd6;
        if (out_valid) record();
        @(negedge clk);
        in_valid = 1'b0;
        if (out_valid) record();
        drain_all();
        check("R3 entries", 32'(ngot), 32'(DEPTH + 1));
        check_fill("R3", 15'h0100);
        check("R3 R8 prog only code", 32'(got_d[DEPTH]), 32'(err_word(5'b00111)));
    endtask

    task automatic t_same_cycle();
        int fire = 0;
        ngot = 0;
        fill(15'h0100);
        send(2'd0, 15'h5555, 4'd7);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            out_ready = 1'b1;
            in_valid = 1'b0;
            if (fire == 1) begin
                in_valid = 1'b1; in_class = 2'd2; in_data = 15'h1234; in_len = 4'd9;
                fire = 2;
            end
            if (out_valid) begin
                record();
                if (ngot == DEPTH) fire = 1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
        check("R10 entries", 32'(ngot), 32'(DEPTH + 2));
        check_fill("R10", 15'h0100);
        check("R10 R7 err first", 32'(got_d[DEPTH]), 32'(err_word(5'b00000)));
        check("R10 msg after err", 32'(got_d[DEPTH + 1]), 32'h1234);
        check("R10 msg len", 32'(got_l[DEPTH + 1]), 32'd9);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_order();
        t_overrun("R7 own", 2'd0, 1, 2'd0, 2'd0, 5'b00000);
        t_overrun("R8 own+prog", 2'd0, 1, 2'd1, 2'd0, 5'b00111);
        t_overrun("R8 own+data", 2'd0, 2, 2'd0, 2'd2, 5'b00111);
        t_overrun("R9 own+watch", 2'd0, 1, 2'd3, 2'd0, 5'b01000);
        t_overrun("R11 own after watch", 2'd0, 0, 2'd0, 2'd0, 5'b00000);
        t_overrun("R9 prog+watch+own", 2'd1, 2, 2'd3, 2'd0, 5'b01000);
        t_overrun("R11 data after watch", 2'd2, 0, 2'd0, 2'd0, 5'b00111);
        t_full_pop();
        t_same_cycle();
        t_order();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule